// File: doc/BRIEF.md
# Cascaded Peripheral Clock Divider

This block turns a small set of source clock enables into one clock enable per peripheral channel. Every source is modelled as a single-cycle enable pulse in one clock domain. Each channel picks a source with a 4-bit select code and divides it in two stages. The first stage divides by the ratio field plus one. The second stage divides the result by the prescaler field plus one. The output is a single-cycle enable pulse.

The configuration lives in three packed 32-bit words: a select word, a ratio word and a prescaler word. Channels share these words, and each channel's fields sit at fixed per-channel offsets. A write names a word, a channel and a value. Only that channel's field changes, and all other bits of the word keep their value. A channel can lack a select field, in which case it uses a fixed source. A channel can also lack a prescaler, in which case only the first stage is used. For each channel the block reports the division factor in use, so that software can work out the output rate.

New divider values are picked up only when the current divide cycle ends. A reconfiguration therefore never shortens a pulse period already in progress.

Top module: `clkdiv_cascade`

## Requirements
- R1: After reset, all three configuration words are zero, no channel error is raised, no output pulse is active, and every channel reports a division factor of 1.
- R2: A write changes only the bits of the addressed field of the addressed channel. The value is truncated to the field width. A write to a field that the channel does not have leaves every word unchanged.
- R3: The write kind selects the word: 0 is the select word, 1 the ratio word, 2 the prescaler word. Ratio fields: channel 0 at bits 3:0, channel 1 at 7:4, channel 2 at 11:8, channel 3 at 21:12 (10 bits). Prescaler fields: channel 1 at 15:8, channel 2 at 7:0, channel 3 at 23:16. Select fields: channel 0 at 3:0, channel 1 at 7:4, channel 3 at 11:8.
- R4: With ratio r and prescaler p in use, a channel emits one output pulse for every (r+1)*(p+1) pulses of its selected source. The pulse appears one cycle after the source pulse that completes the count.
- R5: A select code k below 3 picks source k. Channel 2 has no select field and always uses source 1.
- R6: A select code of 3 or more raises that channel's error output and holds its output pulse low. Its counters do not advance.
- R7: Ratio and prescaler values written during a divide cycle take effect only at that cycle's terminal count. A write registered on the same edge as the terminal count is picked up at the following terminal count. No shortened period appears.
- R8: The division factor output equals (r+1)*(p+1) of the values in use, and it changes only together with an output pulse.
- R9: With ratio 0 and prescaler 0, each selected source pulse is passed to the output one cycle later.
- R10: A channel without a prescaler divides by ratio+1 only.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| src_en_i | input | NUM_SRC | Source enable pulses |
| wr_en_i | input | 1 | Field write strobe |
| wr_kind_i | input | 2 | Word select: 0 select, 1 ratio, 2 prescaler |
| wr_ch_i | input | CH_W | Channel addressed by the write |
| wr_val_i | input | VAL_W | Field value |
| cfg_src_o | output | 32 | Packed select word |
| cfg_rat_o | output | 32 | Packed ratio word |
| cfg_pre_o | output | 32 | Packed prescaler word |
| out_en_o | output | NUM_CH | Per-channel divided enable pulse |
| err_o | output | NUM_CH | Per-channel invalid-source flag |
| div_factor_o | output | NUM_CH*DIV_W | Per-channel division factor in use, channel c at bits c*DIV_W upward |

## Verification
Two things can fall on the same clock edge: a configuration write and the terminal count that loads a new divide value. The bench first moves a channel from a period of 4 to a period of 2 with a write made in the middle of a cycle, and checks that the old period still completes exactly. It then times a second write so that the field register updates on the same edge as a terminal count. The expected result is that the old field value is captured at that edge, one more period of 2 follows, and only then does the output run at the new rate. Pulse positions and the reported factor are checked on each of those cycles.

// File: rtl/clkdiv_pkg.sv
package clkdiv_pkg;
    localparam int unsigned REG_W  = 32;
    localparam int unsigned SEL_W  = 4;
    localparam int unsigned KIND_W = 2;

    typedef enum logic [KIND_W-1:0] {
        KIND_SRC = 2'd0,
        KIND_RAT = 2'd1,
        KIND_PRE = 2'd2
    } wr_kind_e;

    localparam int unsigned CH_DEF = 4;
    // per-channel layout of the packed words
    localparam int unsigned DEF_HAS_SRC [CH_DEF] = '{1, 1, 0, 1};
    localparam int unsigned DEF_SRC_LSB [CH_DEF] = '{0, 4, 0, 8};
    localparam int unsigned DEF_FIX_SRC [CH_DEF] = '{0, 0, 1, 0};
    localparam int unsigned DEF_RAT_LSB [CH_DEF] = '{0, 4, 8, 12};
    localparam int unsigned DEF_RAT_W   [CH_DEF] = '{4, 4, 4, 10};
    localparam int unsigned DEF_HAS_PRE [CH_DEF] = '{0, 1, 1, 1};
    localparam int unsigned DEF_PRE_LSB [CH_DEF] = '{0, 8, 0, 16};
    localparam int unsigned DEF_PRE_W   [CH_DEF] = '{1, 8, 8, 8};
endpackage

// File: rtl/clkdiv_cfg_regs.sv
module clkdiv_cfg_regs
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_CH = CH_DEF,
    parameter int unsigned VAL_W  = 10,
    parameter int unsigned CH_W   = $clog2(NUM_CH),
    parameter int unsigned HAS_SRC [NUM_CH] = DEF_HAS_SRC,
    parameter int unsigned SRC_LSB [NUM_CH] = DEF_SRC_LSB,
    parameter int unsigned RAT_LSB [NUM_CH] = DEF_RAT_LSB,
    parameter int unsigned RAT_W   [NUM_CH] = DEF_RAT_W,
    parameter int unsigned HAS_PRE [NUM_CH] = DEF_HAS_PRE,
    parameter int unsigned PRE_LSB [NUM_CH] = DEF_PRE_LSB,
    parameter int unsigned PRE_W   [NUM_CH] = DEF_PRE_W
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [KIND_W-1:0] wr_kind_i,
    input  logic [CH_W-1:0]   wr_ch_i,
    input  logic [VAL_W-1:0]  wr_val_i,
    output logic [REG_W-1:0]  src_word_o,
    output logic [REG_W-1:0]  rat_word_o,
    output logic [REG_W-1:0]  pre_word_o
);
    typedef struct packed {
        logic [REG_W-1:0] src;
        logic [REG_W-1:0] rat;
        logic [REG_W-1:0] pre;
    } regs_t;

    regs_t            regs_d, regs_q;
    logic             hit;
    int unsigned      lsb, wid;
    logic [REG_W-1:0] fmask, fval;

    always_comb begin
        regs_d = regs_q;
        hit    = 1'b0;
        lsb    = 0;
        wid    = 0;
        for (int c = 0; c < NUM_CH; c++) begin
            if (wr_ch_i == CH_W'(c)) begin
                case (wr_kind_i)
                    KIND_SRC: begin hit = (HAS_SRC[c] != 0); lsb = SRC_LSB[c]; wid = SEL_W;    end
                    KIND_RAT: begin hit = 1'b1;              lsb = RAT_LSB[c]; wid = RAT_W[c]; end
                    KIND_PRE: begin hit = (HAS_PRE[c] != 0); lsb = PRE_LSB[c]; wid = PRE_W[c]; end
                    default:  hit = 1'b0;
                endcase
            end
        end
        fmask = ((REG_W'(1) << wid) - REG_W'(1)) << lsb;
        fval  = (REG_W'(wr_val_i) << lsb) & fmask;
        if (wr_en_i && hit) begin
            case (wr_kind_i)
                KIND_SRC: regs_d.src = (regs_q.src & ~fmask) | fval;
                KIND_RAT: regs_d.rat = (regs_q.rat & ~fmask) | fval;
                KIND_PRE: regs_d.pre = (regs_q.pre & ~fmask) | fval;
                default:  ;
            endcase
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) regs_q <= '0;
        else         regs_q <= regs_d;
    end

    assign src_word_o = regs_q.src;
    assign rat_word_o = regs_q.rat;
    assign pre_word_o = regs_q.pre;
endmodule

// File: rtl/clkdiv_chan.sv
module clkdiv_chan
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned RAT_W   = 4,
    parameter int unsigned PRE_W   = 8,
    parameter int unsigned DIV_W   = 22
) (
    input  logic               clk_i,
    input  logic               rst_ni,
    input  logic [NUM_SRC-1:0] src_en_i,
    input  logic [SEL_W-1:0]   sel_i,
    input  logic [RAT_W-1:0]   rat_i,
    input  logic [PRE_W-1:0]   pre_i,
    output logic               tick_o,
    output logic               err_o,
    output logic [DIV_W-1:0]   div_o
);
    typedef struct packed {
        logic [RAT_W-1:0] cnt1;
        logic [PRE_W-1:0] cnt2;
        logic [RAT_W-1:0] act_rat;
        logic [PRE_W-1:0] act_pre;
        logic             tick;
    } st_t;

    st_t              st_d, st_q;
    logic             pick, valid;
    logic [DIV_W-1:0] f1, f2;

    always_comb begin
        pick  = 1'b0;
        valid = 1'b0;
        for (int k = 0; k < NUM_SRC; k++) begin
            if (sel_i == SEL_W'(k)) begin
                pick  = src_en_i[k];
                valid = 1'b1;
            end
        end
    end

    always_comb begin
        st_d      = st_q;
        st_d.tick = 1'b0;
        if (pick) begin
            if (st_q.cnt1 == st_q.act_rat) begin
                st_d.cnt1 = '0;
                if (st_q.cnt2 == st_q.act_pre) begin
                    // terminal count: emit and pick up pending values
                    st_d.cnt2    = '0;
                    st_d.tick    = 1'b1;
                    st_d.act_rat = rat_i;
                    st_d.act_pre = pre_i;
                end else begin
                    st_d.cnt2 = st_q.cnt2 + 1'b1;
                end
            end else begin
                st_d.cnt1 = st_q.cnt1 + 1'b1;
            end
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) st_q <= '0;
        else         st_q <= st_d;
    end

    assign f1     = DIV_W'(st_q.act_rat) + DIV_W'(1);
    assign f2     = DIV_W'(st_q.act_pre) + DIV_W'(1);
    assign div_o  = f1 * f2;
    assign tick_o = st_q.tick;
    assign err_o  = !valid;
endmodule

// File: rtl/clkdiv_cascade.sv
module clkdiv_cascade
    import clkdiv_pkg::*;
#(
    parameter int unsigned NUM_CH  = CH_DEF,
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned VAL_W   = 10,
    parameter int unsigned HAS_SRC [NUM_CH] = DEF_HAS_SRC,
    parameter int unsigned SRC_LSB [NUM_CH] = DEF_SRC_LSB,
    parameter int unsigned FIX_SRC [NUM_CH] = DEF_FIX_SRC,
    parameter int unsigned RAT_LSB [NUM_CH] = DEF_RAT_LSB,
    parameter int unsigned RAT_W   [NUM_CH] = DEF_RAT_W,
    parameter int unsigned HAS_PRE [NUM_CH] = DEF_HAS_PRE,
    parameter int unsigned PRE_LSB [NUM_CH] = DEF_PRE_LSB,
    parameter int unsigned PRE_W   [NUM_CH] = DEF_PRE_W,
    localparam int unsigned CH_W   = $clog2(NUM_CH),
    localparam int unsigned DIV_W  = 2 * VAL_W + 2
) (
    input  logic                    clk_i,
    input  logic                    rst_ni,
    input  logic [NUM_SRC-1:0]      src_en_i,
    input  logic                    wr_en_i,
    input  logic [KIND_W-1:0]       wr_kind_i,
    input  logic [CH_W-1:0]         wr_ch_i,
    input  logic [VAL_W-1:0]        wr_val_i,
    output logic [REG_W-1:0]        cfg_src_o,
    output logic [REG_W-1:0]        cfg_rat_o,
    output logic [REG_W-1:0]        cfg_pre_o,
    output logic [NUM_CH-1:0]       out_en_o,
    output logic [NUM_CH-1:0]       err_o,
    output logic [NUM_CH*DIV_W-1:0] div_factor_o
);
    clkdiv_cfg_regs #(
        .NUM_CH(NUM_CH), .VAL_W(VAL_W), .CH_W(CH_W),
        .HAS_SRC(HAS_SRC), .SRC_LSB(SRC_LSB),
        .RAT_LSB(RAT_LSB), .RAT_W(RAT_W),
        .HAS_PRE(HAS_PRE), .PRE_LSB(PRE_LSB), .PRE_W(PRE_W)
    ) u_regs (
        .clk_i(clk_i), .rst_ni(rst_ni),
        .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
        .wr_ch_i(wr_ch_i), .wr_val_i(wr_val_i),
        .src_word_o(cfg_src_o), .rat_word_o(cfg_rat_o), .pre_word_o(cfg_pre_o)
    );

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        logic [SEL_W-1:0]    sel;
        logic [RAT_W[g]-1:0] rat;
        logic [PRE_W[g]-1:0] pre;
        logic [DIV_W-1:0]    div;

        if (HAS_SRC[g] != 0) begin : g_sel
            assign sel = cfg_src_o[SRC_LSB[g] +: SEL_W];
        end else begin : g_fix
            assign sel = SEL_W'(FIX_SRC[g]);
        end

        assign rat = cfg_rat_o[RAT_LSB[g] +: RAT_W[g]];

        if (HAS_PRE[g] != 0) begin : g_pre
            assign pre = cfg_pre_o[PRE_LSB[g] +: PRE_W[g]];
        end else begin : g_nopre
            assign pre = '0;
        end

        clkdiv_chan #(
            .NUM_SRC(NUM_SRC), .RAT_W(RAT_W[g]), .PRE_W(PRE_W[g]), .DIV_W(DIV_W)
        ) u_chan (
            .clk_i(clk_i), .rst_ni(rst_ni), .src_en_i(src_en_i),
            .sel_i(sel), .rat_i(rat), .pre_i(pre),
            .tick_o(out_en_o[g]), .err_o(err_o[g]), .div_o(div)
        );

        assign div_factor_o[g*DIV_W +: DIV_W] = div;
    end
endmodule

// File: rtl/clkdiv_chk.sv
module clkdiv_chk #(
    parameter int unsigned NUM_CH  = 4,
    parameter int unsigned NUM_SRC = 3,
    parameter int unsigned DIV_W   = 22
) (
    input logic                    clk_i,
    input logic                    rst_ni,
    input logic [NUM_SRC-1:0]      src_en_i,
    input logic                    wr_en_i,
    input logic [1:0]              wr_kind_i,
    input logic [31:0]             cfg_src_o,
    input logic [31:0]             cfg_rat_o,
    input logic [31:0]             cfg_pre_o,
    input logic [NUM_CH-1:0]       out_en_o,
    input logic [NUM_CH-1:0]       err_o,
    input logic [NUM_CH*DIV_W-1:0] div_factor_o
);
    a_r2_src_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && !($past(wr_en_i) && $past(wr_kind_i) == 2'd0) |-> cfg_src_o == $past(cfg_src_o));
    a_r2_rat_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && !($past(wr_en_i) && $past(wr_kind_i) == 2'd1) |-> cfg_rat_o == $past(cfg_rat_o));
    a_r2_pre_word_hold: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(rst_ni) && !($past(wr_en_i) && $past(wr_kind_i) == 2'd2) |-> cfg_pre_o == $past(cfg_pre_o));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        a_r4_needs_source: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && !$past(|src_en_i) |-> !out_en_o[i]);
        a_r6_err_silences: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && $past(err_o[i]) |-> !out_en_o[i]);
        a_r9_pass_through: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && $past(div_factor_o[i*DIV_W +: DIV_W]) == 1
            && $past(&src_en_i) && !$past(err_o[i]) |-> out_en_o[i]);
        a_r8_factor_with_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
            $past(rst_ni) && div_factor_o[i*DIV_W +: DIV_W] != $past(div_factor_o[i*DIV_W +: DIV_W])
            |-> out_en_o[i]);
        a_r8_factor_nonzero: assert property (@(posedge clk_i) disable iff (!rst_ni)
            div_factor_o[i*DIV_W +: DIV_W] != 0);
    end
endmodule

bind clkdiv_cascade clkdiv_chk #(
    .NUM_CH(NUM_CH), .NUM_SRC(NUM_SRC), .DIV_W(DIV_W)
) u_chk (
    .clk_i(clk_i), .rst_ni(rst_ni), .src_en_i(src_en_i),
    .wr_en_i(wr_en_i), .wr_kind_i(wr_kind_i),
    .cfg_src_o(cfg_src_o), .cfg_rat_o(cfg_rat_o), .cfg_pre_o(cfg_pre_o),
    .out_en_o(out_en_o), .err_o(err_o), .div_factor_o(div_factor_o)
);

// File: tb/tb_clkdiv_cascade.sv
module tb_clkdiv_cascade;
    localparam int CLK_PERIOD = 10;
    localparam int NCH = 4;
    localparam int DW  = 22;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic [2:0]      src = '0;
    logic            wr_en = 1'b0;
    logic [1:0]      wr_kind = '0;
    logic [1:0]      wr_ch = '0;
    logic [9:0]      wr_val = '0;
    logic [31:0]     cfg_src, cfg_rat, cfg_pre;
    logic [NCH-1:0]  out_en, err;
    logic [NCH*DW-1:0] divf;

    int n_chk = 0;
    int n_bad = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    clkdiv_cascade dut (
        .clk_i(clk), .rst_ni(rst_n), .src_en_i(src),
        .wr_en_i(wr_en), .wr_kind_i(wr_kind), .wr_ch_i(wr_ch), .wr_val_i(wr_val),
        .cfg_src_o(cfg_src), .cfg_rat_o(cfg_rat), .cfg_pre_o(cfg_pre),
        .out_en_o(out_en), .err_o(err), .div_factor_o(divf)
    );

    typedef struct packed { int ch; int sel; int rat; int pre; } vec_t;
    localparam vec_t VEC [8] = '{
        '{0, 0, 3, 0}, '{1, 1, 2, 3}, '{1, 2, 0, 4}, '{2, 0, 1, 1},
        '{3, 2, 600, 0}, '{3, 0, 5, 9}, '{0, 1, 0, 0}, '{2, 0, 0, 0}
    };
    localparam int HAS_PRE [NCH] = '{0, 1, 1, 1};
    localparam int HAS_SEL [NCH] = '{1, 1, 0, 1};

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic longint fac(input int ch);
        return longint'(divf[ch*DW +: DW]);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0; src = '0; wr_en = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic wr(input int kind, input int ch, input int val);
        @(negedge clk);
        wr_en = 1'b1; wr_kind = 2'(kind); wr_ch = 2'(ch); wr_val = 10'(val);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic wait_pulse(input int ch, output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 3000; i++) begin
            @(negedge clk);
            if (out_en[ch]) begin seen = 1'b1; break; end
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        bit seen;
        int cnt;
        longint exp;

        do_reset();
        // R1 reset state
        chk(cfg_src == 0 && cfg_rat == 0 && cfg_pre == 0, "R1 words", longint'(cfg_rat), 0);
        chk(out_en == 0 && err == 0, "R1 outputs", longint'({out_en, err}), 0);
        for (int c = 0; c < NCH; c++) chk(fac(c) == 1, "R1 factor", fac(c), 1);

        // table walk: R4 R8 R10
        for (int v = 0; v < 8; v++) begin
            src = '0;
            if (HAS_SEL[VEC[v].ch] != 0) wr(0, VEC[v].ch, VEC[v].sel);
            wr(1, VEC[v].ch, VEC[v].rat);
            if (HAS_PRE[VEC[v].ch] != 0) wr(2, VEC[v].ch, VEC[v].pre);
            exp = longint'(VEC[v].rat + 1) * ((HAS_PRE[VEC[v].ch] != 0) ? VEC[v].pre + 1 : 1);
            src = 3'b111;
            wait_pulse(VEC[v].ch, seen);
            chk(seen, "R4 first pulse", longint'(seen), 1);
            chk(fac(VEC[v].ch) == exp, "R8 R10 factor", fac(VEC[v].ch), exp);
            cnt = 0;
            for (int i = 0; i < 3000; i++) begin
                @(negedge clk);
                cnt++;
                if (out_en[VEC[v].ch]) break;
            end
            chk(cnt == exp, "R4 R10 period", cnt, exp);
        end
        src = '0;

        // R2 R3 field layout and read-modify-write
        do_reset();
        wr(1, 0, 3); wr(1, 2, 7); wr(1, 1, 5); wr(1, 3, 10'h3FF);
        chk(cfg_rat == 32'h003FF753, "R3 ratio layout", longint'(cfg_rat), 32'h003FF753);
        wr(1, 1, 10'hA);
        chk(cfg_rat == 32'h003FF7A3, "R2 neighbours kept", longint'(cfg_rat), 32'h003FF7A3);
        wr(1, 0, 10'h3F7);
        chk(cfg_rat == 32'h003FF7A7, "R2 truncation", longint'(cfg_rat), 32'h003FF7A7);
        wr(2, 0, 10'hFF);
        chk(cfg_pre == 0, "R2 absent prescaler", longint'(cfg_pre), 0);
        wr(0, 2, 5);
        chk(cfg_src == 0, "R2 absent select", longint'(cfg_src), 0);
        wr(2, 3, 10'h5A); wr(2, 1, 10'h11); wr(0, 3, 2);
        chk(cfg_pre == 32'h005A1100, "R3 prescaler layout", longint'(cfg_pre), 32'h005A1100);
        chk(cfg_src == 32'h00000200, "R3 select layout", longint'(cfg_src), 32'h200);

        // R5 source selection and fixed source
        do_reset();
        wr(0, 0, 2);
        src = 3'b001; @(negedge clk);
        chk(out_en[2] == 1'b0, "R5 fixed source ignores 0", longint'(out_en[2]), 0);
        src = 3'b010; @(negedge clk);
        chk(out_en[0] == 1'b0, "R5 unselected source", longint'(out_en[0]), 0);
        chk(out_en[2] == 1'b1, "R5 fixed source 1", longint'(out_en[2]), 1);
        src = 3'b100; @(negedge clk);
        chk(out_en[0] == 1'b1, "R5 selected source 2", longint'(out_en[0]), 1);
        src = '0;

        // R6 invalid code
        do_reset();
        wr(0, 0, 9);
        chk(err[0] == 1'b1, "R6 error raised", longint'(err[0]), 1);
        src = 3'b111;
        seen = 1'b0;
        repeat (4) begin @(negedge clk); if (out_en[0]) seen = 1'b1; end
        chk(!seen, "R6 output held low", longint'(seen), 0);
        src = '0;
        wr(0, 0, 0);
        chk(err[0] == 1'b0, "R6 error cleared", longint'(err[0]), 0);
        src = 3'b001; @(negedge clk);
        chk(out_en[0] == 1'b1, "R6 resumes", longint'(out_en[0]), 1);
        src = '0;

        // R9 pass-through of a sparse pattern
        do_reset();
        for (int i = 0; i < 6; i++) begin
            src = {2'b00, 1'(6'b101101 >> i)};
            @(negedge clk);
            chk(out_en[0] == src[0], "R9 pass-through", longint'(out_en[0]), longint'(src[0]));
        end
        src = '0;

        // R7 pending update: mid-cycle write, then write on terminal edge
        do_reset();
        wr(1, 1, 3);
        src = 3'b001;
        wait_pulse(1, seen);
        chk(seen && fac(1) == 4, "R7 loaded ratio 3", fac(1), 4);
        @(negedge clk); wr_en = 1'b1; wr_kind = 2'd1; wr_ch = 2'd1; wr_val = 10'd1;
        chk(out_en[1] == 1'b0, "R7 no runt 1", longint'(out_en[1]), 0);
        @(negedge clk); wr_en = 1'b0;
        chk(out_en[1] == 1'b0, "R7 no runt 2", longint'(out_en[1]), 0);
        @(negedge clk);
        chk(out_en[1] == 1'b0, "R7 no runt 3", longint'(out_en[1]), 0);
        @(negedge clk);
        chk(out_en[1] == 1'b1 && fac(1) == 2, "R7 old period ends", fac(1), 2);
        @(negedge clk);
        chk(out_en[1] == 1'b0, "R7 new period gap", longint'(out_en[1]), 0);
        @(negedge clk);
        chk(out_en[1] == 1'b1, "R7 new period 2", longint'(out_en[1]), 1);
        @(negedge clk); wr_en = 1'b1; wr_kind = 2'd1; wr_ch = 2'd1; wr_val = 10'd0;
        @(negedge clk); wr_en = 1'b0;
        chk(out_en[1] == 1'b1 && fac(1) == 2, "R7 same-edge keeps old", fac(1), 2);
        @(negedge clk);
        chk(out_en[1] == 1'b0, "R7 one more period", longint'(out_en[1]), 0);
        @(negedge clk);
        chk(out_en[1] == 1'b1 && fac(1) == 1, "R7 new value loaded", fac(1), 1);
        @(negedge clk);
        chk(out_en[1] == 1'b1, "R7 rate 1", longint'(out_en[1]), 1);
        src = '0;

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule